// File: doc/BRIEF.md
# Watchdog Timer with Keyed Clear

A 16-bit counter that steps on a slow tick enable and serves either as a general-purpose interval timer or as a system watchdog. Software programs it through a small word-wide register port that has three writable locations. The control word sets the count direction, run enable, periodic or free-running behaviour, watchdog mode, keyed (secure) clearing, a prescaler field, interrupt-instead-of-reset on expiry, and halting while the peripherals are powered down. The load word gives the start and reload value. The clear location services the watchdog.

In watchdog mode the counter must be serviced by writing the clear location before the count runs out. With keyed clearing enabled, each service write must carry the next value of a hidden 8-bit Galois LFSR that software seeded before entering watchdog mode. A wrong key raises the reset request at once, without waiting for the count to run out. The reset request is a single-cycle pulse. After the pulse the block is back in its power-on state.

Top module: `wdt_lfsr_timer`

## Requirements
- R1: After reset, the control word reads 0x0000, the count reads 0, irq is low and rst_req is low. Control bits 15:9 always read as zero.
- R2: Control bit 7 is the run enable. With it set and bit 8 clear, each cycle with tick high lowers the count by one. Without tick, or with bit 7 clear, the count holds. A load write (wr_sel=1) sets both the load value and the count.
- R3: With control bit 8 set, each tick raises the count by one.
- R4: With control bit 6 clear (free-running), counting down wraps from 0 to 0xFFFF and counting up wraps from 0xFFFF to 0.
- R5: With control bit 6 set (periodic), a tick at the terminal value (0 counting down, 0xFFFF counting up) reloads the load value.
- R6: With control bit 0 set, the count holds while pwr_down is high. With bit 0 clear, the count keeps running during power-down.
- R7: Every code of the prescaler field (bits 3:2) steps the counter once per tick.
- R8: Outside watchdog mode, a tick at the terminal value sets irq. Any write to the clear location (wr_sel=2) clears irq.
- R9: In watchdog mode (bit 5) with bit 1 clear, a tick at count 0 raises rst_req for exactly one cycle. In that same cycle the control word, count and irq are zero.
- R10: In watchdog mode with bit 1 set, a tick at count 0 sets irq, reloads the counter and raises no reset.
- R11: In watchdog mode with bit 4 clear, any clear write reloads the count from the load value.
- R12: Outside watchdog mode, a clear write stores its low byte as the LFSR seed. In watchdog mode with bit 4 set, a clear write whose low byte equals the LFSR reloads the count and advances the LFSR by one step (shift left, XOR 0x63 if the bit shifted out was 1). The seed 0xAA gives the keys 0xAA, 0x37, 0x6E, 0xDC.
- R13: In keyed watchdog mode, a clear write with the wrong key raises rst_req on the next cycle even before the count runs out. An LFSR value of 0x00 always raises it.
- R14: Reading the clear location (rd_sel=3) always returns 0, so the LFSR cannot be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the 32.768 kHz domain |
| pwr_down | input | 1 | Peripheral power-down indication |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 load, 2 clear |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read source: 0 control, 1 load, 2 count, 3 clear (reads 0) |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Interrupt flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench sweeps periodic reload in both directions across several full periods. Each expected count comes from modular arithmetic, which catches an off-by-one reload that skips or repeats the terminal value. It also drives the free-running wrap at both ends: a design that saturated, or that reloaded where it should wrap, shows the wrong count there. The watchdog cases cover expiry with and without interrupt enable, a plain clear, the keyed sequence 0xAA/0x37/0x6E, a wrong key, and a zero seed. A design with the wrong taps or shift direction resets on the second key. A design that waited for expiry never pulses after a wrong key. A design that left control bits set after the pulse keeps counting afterwards.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int CTRL_W = 9;

  // Control word, most significant field first so that bit positions match.
  typedef struct packed {
    logic       up;      // bit 8
    logic       en;      // bit 7
    logic       per;     // bit 6
    logic       wd;      // bit 5
    logic       sec;     // bit 4
    logic [1:0] pre;     // bits 3:2
    logic       wirq;    // bit 1
    logic       pdstop;  // bit 0
  } ctrl_t;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_LOAD  = 2'd1;
  localparam logic [1:0] SEL_CLR   = 2'd2;
  localparam logic [1:0] SEL_COUNT = 2'd2;
  localparam logic [1:0] SEL_KEY   = 2'd3;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         up,
  input  logic         reload_term,
  output logic [W-1:0] cnt,
  output logic         term_hit
);

  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = {W{1'b0}};

  logic [W-1:0] cnt_d;

  assign term_hit = step_en && (cnt == (up ? TOP : BOT));

  always_comb begin
    cnt_d = cnt;
    if (soft_clr) begin
      cnt_d = BOT;
    end else if (load_en || (term_hit && reload_term)) begin
      cnt_d = load_val;
    end else if (step_en) begin
      cnt_d = up ? cnt + 1'b1 : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= BOT;
    else        cnt <= cnt_d;
  end

  // R4: a free-running down count steps from zero to all ones
  a_r4_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !up && !reload_term && !load_en && !soft_clr && cnt == BOT)
      |=> cnt == TOP);

endmodule

// File: rtl/wdt_lfsr.sv
module wdt_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'h63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic         seed_en,
  input  logic [W-1:0] seed,
  input  logic         adv_en,
  output logic [W-1:0] key
);

  logic [W-1:0] key_d;
  logic [W-1:0] stepped;

  assign stepped = {key[W-2:0], 1'b0} ^ (key[W-1] ? TAPS : {W{1'b0}});

  always_comb begin
    key_d = key;
    if (soft_clr)     key_d = '0;
    else if (seed_en) key_d = seed;
    else if (adv_en)  key_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key <= '0;
    else        key <= key_d;
  end

  // R13: the all-zero state never leaves zero by stepping
  a_r13_zero_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (key == '0 && !seed_en) |=> key == '0);

endmodule

// File: rtl/wdt_lfsr_timer.sv
module wdt_lfsr_timer
  import wdt_pkg::*;
#(
  parameter int              CNT_W    = 16,
  parameter int              KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_TAPS = 8'h63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwr_down,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq,
  output logic             rst_req
);

  localparam int PAD_W = CNT_W - CTRL_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic             irq_d, rst_req_d;
  logic [CNT_W-1:0] cnt;
  logic [KEY_W-1:0] key;
  logic             term_hit;

  logic ctrl_wr, load_wr, clr_wr;
  logic pre_tick, step_en;
  logic key_ok, bad_clear, good_clear, wd_expire, fire;
  logic cnt_load_en;
  logic [CNT_W-1:0] cnt_load_val;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign load_wr = wr_en && (wr_sel == SEL_LOAD);
  assign clr_wr  = wr_en && (wr_sel == SEL_CLR);

  // prescaler: every code divides by one
  always_comb begin
    case (ctrl_q.pre)
      2'b00:   pre_tick = tick;
      default: pre_tick = tick;
    endcase
  end

  assign step_en = ctrl_q.en && pre_tick && !(ctrl_q.pdstop && pwr_down);

  assign key_ok     = (key != '0) && (wr_data[KEY_W-1:0] == key);
  assign bad_clear  = clr_wr && ctrl_q.wd && ctrl_q.sec && !key_ok;
  assign good_clear = clr_wr && ctrl_q.wd && !bad_clear;
  assign wd_expire  = term_hit && ctrl_q.wd && !ctrl_q.wirq;
  assign fire       = bad_clear || (wd_expire && !good_clear);

  assign cnt_load_en  = load_wr || good_clear;
  assign cnt_load_val = load_wr ? wr_data : load_q;

  always_comb begin
    ctrl_d    = ctrl_q;
    load_d    = load_q;
    irq_d     = irq;
    rst_req_d = 1'b0;
    if (fire) begin
      ctrl_d    = '0;
      irq_d     = 1'b0;
      rst_req_d = 1'b1;
    end else begin
      if (ctrl_wr) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
      if (load_wr) load_d = wr_data;
      if (clr_wr)  irq_d  = 1'b0;
      if (term_hit && (!ctrl_q.wd || ctrl_q.wirq)) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      load_q  <= load_d;
      irq     <= irq_d;
      rst_req <= rst_req_d;
    end
  end

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .soft_clr    (fire),
    .load_en     (cnt_load_en),
    .load_val    (cnt_load_val),
    .step_en     (step_en),
    .up          (ctrl_q.up),
    .reload_term (ctrl_q.per || ctrl_q.wd),
    .cnt         (cnt),
    .term_hit    (term_hit)
  );

  wdt_lfsr #(.W(KEY_W), .TAPS(KEY_TAPS)) u_key (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .soft_clr (fire),
    .seed_en  (clr_wr && !ctrl_q.wd),
    .seed     (wr_data[KEY_W-1:0]),
    .adv_en   (good_clear && ctrl_q.sec),
    .key      (key)
  );

  always_comb begin
    case (rd_sel)
      SEL_CTRL:  rd_data = {{PAD_W{1'b0}}, ctrl_q};
      SEL_LOAD:  rd_data = load_q;
      SEL_COUNT: rd_data = cnt;
      default:   rd_data = '0;
    endcase
  end

  // R9: the reset request lasts exactly one cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_req |=> !rst_req);

  // R9: while the request is high the block is back in its default state
  a_r9_defaults: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_req |-> (ctrl_q == '0 && cnt == '0 && !irq));

  // R13: a wrong key is answered on the very next cycle
  a_r13_bad_key: assert property (@(posedge clk) disable iff (!rst_int_n)
    bad_clear |=> rst_req);

  // R6: power-down with the stop bit set freezes the count
  a_r6_pd_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_q.pdstop && pwr_down && !wr_en) |=> $stable(cnt));

  // R11: an accepted service write restores the load value
  a_r11_reload: assert property (@(posedge clk) disable iff (!rst_int_n)
    good_clear |=> cnt == $past(load_q));

  // R10: with interrupt-on-expiry and no clear write, no reset is requested
  a_r10_no_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_q.wd && ctrl_q.wirq && !clr_wr) |=> !rst_req);

endmodule

// File: tb/wdt_lfsr_timer_test.sv
module wdt_lfsr_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        pwr_down = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        irq;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int rst_seen = 0;

  always #10 clk = ~clk;

  wdt_lfsr_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_down(pwr_down),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_req) rst_seen++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    #1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic chk_cnt(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(2'd2, v); chk(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    chk_cnt("R1 count", 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 rst_req", rst_seen[15:0], 16'h0);
    wr(2'd0, 16'hFE00);
    rd(2'd0, v); chk("R1 reserved bits", v, 16'h0000);

    // R2 down counting, hold without tick or enable
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0080);
    repeat (5) @(negedge clk); #1;
    chk_cnt("R2 no tick hold", 16'd10);
    for (int k = 1; k <= 5; k++) begin
      ticks(1); chk_cnt("R2 down step", 16'(10 - k));
    end
    wr(2'd0, 16'h0000);
    ticks(2); chk_cnt("R2 disabled hold", 16'd5);

    // R4 free-running wrap down, R8 irq set and clear
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0080);
    ticks(2); chk_cnt("R4 reach zero", 16'd0);
    chk("R8 irq before terminal", {15'b0, irq}, 16'h0);
    ticks(1); chk_cnt("R4 wrap down", 16'hFFFF);
    chk("R8 irq at terminal", {15'b0, irq}, 16'h1);
    wr(2'd2, 16'h0000);
    chk("R8 irq cleared", {15'b0, irq}, 16'h0);

    // R3 up counting, R4 wrap up
    wr(2'd1, 16'hFFFD);
    wr(2'd0, 16'h0180);
    ticks(1); chk_cnt("R3 up step", 16'hFFFE);
    ticks(1); chk_cnt("R3 up step", 16'hFFFF);
    ticks(1); chk_cnt("R4 wrap up", 16'h0000);

    // R5 periodic sweeps
    wr(2'd1, 16'd4);
    wr(2'd0, 16'h00C0);
    for (int k = 1; k <= 15; k++) begin
      ticks(1); chk_cnt("R5 periodic down", 16'(4 - (k % 5)));
    end
    wr(2'd1, 16'hFFFA);
    wr(2'd0, 16'h01C0);
    for (int k = 1; k <= 18; k++) begin
      ticks(1); chk_cnt("R5 periodic up", 16'(16'hFFFA + (k % 6)));
    end

    // R7 prescaler codes
    for (int p = 1; p <= 3; p++) begin
      wr(2'd1, 16'd20);
      wr(2'd0, 16'(16'h0080 | (p << 2)));
      ticks(3); chk_cnt("R7 prescaler divide by one", 16'd17);
    end

    // R6 power-down stop
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h0081);
    pwr_down = 1'b1;
    ticks(3); chk_cnt("R6 halted", 16'd9);
    pwr_down = 1'b0;
    ticks(1); chk_cnt("R6 resumed", 16'd8);
    wr(2'd0, 16'h0080);
    pwr_down = 1'b1;
    ticks(1); chk_cnt("R6 runs without stop bit", 16'd7);
    pwr_down = 1'b0;
    wr(2'd2, 16'h0000);

    // R10 watchdog expiry with irq enable
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h00A2);
    ticks(3); chk_cnt("R10 at zero", 16'd0);
    chk("R10 irq low before expiry", {15'b0, irq}, 16'h0);
    ticks(1); chk_cnt("R10 reloaded", 16'd3);
    chk("R10 irq", {15'b0, irq}, 16'h1);
    chk("R10 no reset", rst_seen[15:0], 16'd0);

    // R11 plain clear, R9 expiry reset
    wr(2'd1, 16'd6);
    wr(2'd0, 16'h00A0);
    ticks(2); chk_cnt("R11 counted", 16'd4);
    wr(2'd2, 16'h1234);
    chk_cnt("R11 reloaded", 16'd6);
    chk("R8 clear write drops irq", {15'b0, irq}, 16'h0);
    chk("R11 no reset", rst_seen[15:0], 16'd0);
    ticks(6); chk_cnt("R9 at zero", 16'd0);
    chk("R9 no reset yet", rst_seen[15:0], 16'd0);
    ticks(1);
    chk("R9 reset pulse", rst_seen[15:0], 16'd1);
    rd(2'd0, v); chk("R9 ctrl cleared", v, 16'h0000);
    chk_cnt("R9 count cleared", 16'd0);
    repeat (3) @(negedge clk); #1;
    chk("R9 single cycle", rst_seen[15:0], 16'd1);

    // R12 keyed sequence, R14 unreadable key, R13 wrong key
    wr(2'd2, 16'h00AA);
    wr(2'd1, 16'd50);
    wr(2'd0, 16'h00B0);
    ticks(2); chk_cnt("R12 counted", 16'd48);
    rd(2'd3, v); chk("R14 key unreadable", v, 16'h0000);
    wr(2'd2, 16'h00AA); chk_cnt("R12 key AA reload", 16'd50);
    ticks(1);
    wr(2'd2, 16'h0037); chk_cnt("R12 key 37 reload", 16'd50);
    ticks(1);
    wr(2'd2, 16'h006E); chk_cnt("R12 key 6E reload", 16'd50);
    chk("R12 no reset on good keys", rst_seen[15:0], 16'd1);
    rd(2'd3, v); chk("R14 key unreadable", v, 16'h0000);
    ticks(1);
    wr(2'd2, 16'h0066);
    chk("R13 wrong key resets", rst_seen[15:0], 16'd2);
    rd(2'd0, v); chk("R13 ctrl cleared", v, 16'h0000);

    // R13 zero seed
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'd50);
    wr(2'd0, 16'h00B0);
    wr(2'd2, 16'h0000);
    chk("R13 zero seed resets", rst_seen[15:0], 16'd3);

    // R12 full sequence including 0xDC
    wr(2'd2, 16'h00AA);
    wr(2'd1, 16'd40);
    wr(2'd0, 16'h00B0);
    wr(2'd2, 16'h00AA);
    wr(2'd2, 16'h0037);
    wr(2'd2, 16'h006E);
    ticks(1);
    wr(2'd2, 16'h00DC); chk_cnt("R12 key DC reload", 16'd40);
    chk("R12 no reset on DC", rst_seen[15:0], 16'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule